// File: doc/BRIEF.md
# Symbol-Period Timer with Compare, Backoff and Interrupt Flags

This block keeps the time base of a low-rate wireless MAC. A 32-bit counter counts symbol periods. The `sym_tick` strobe marks each 16 us period. The counter runs freely and wraps to zero after its largest value.

Software reaches the block through a byte-wide register port. Through that port it can:
- load a new counter value byte by byte;
- program three compare values;
- switch on a backoff slot timer that marks every twentieth symbol.

Events latch into an interrupt flag register, and a mask register decides which flags drive `irq`. A counter load is staged first. It reaches the counter on the next symbol tick, and a busy flag shows that the load is pending.

The register map uses 5-bit addresses:

| Address | Contents |
|---|---|
| 0x00..0x03 | Counter bytes, least significant byte at 0x00 |
| 0x04 | Control |
| 0x05 | Busy flag |
| 0x06 | Interrupt flags |
| 0x07 | Interrupt mask |
| 0x10 + 4*(k-1) + byte | Compare unit k (k = 1..3), least significant byte first |

Top module: `symcnt_timer`

## Requirements
- R1: After reset the counter reads 0. The busy flag, flag register, mask register, control register and `irq` are all 0.
- R2: While no load is pending, each cycle with `sym_tick` high adds one to the counter. In cycles without `sym_tick` the counter holds its value.
- R3: A write to addresses 0x01..0x03 only updates a staging register. A write to address 0x00 stages the low byte and sets the busy flag (address 0x05, bit 0) from the next cycle. The counter keeps its old value until the next tick.
- R4: On the first tick while busy is set, the counter takes the staged value without also counting, and busy clears. That tick raises no overflow or compare flag.
- R5: A counting tick that moves the counter from 0xFFFFFFFF to 0 sets flag bit 3.
- R6: A counting tick that makes the counter equal to compare value k sets flag bit k-1. Compare k is stored at 0x10+4*(k-1)+byte, least significant byte first.
- R7: Bit 0 of the control register (address 0x04) enables the backoff slot timer. While it is enabled, every 20th tick after enabling sets flag bit 4. Clearing the bit resets the slot count to 0.
- R8: The flag register is at address 0x06. Bit 4 is backoff, bit 3 is overflow, and bits 2..0 are compare 3..1. Bits 7:5 read as 0. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: A cycle with `irq_ack` bit n high clears flag bit n.
- R10: The mask register is at address 0x07. `irq` is high exactly when a flag bit and its mask bit are both set.
- R11: `rdata` presents, one cycle later, the register addressed by `addr`. The counter bytes show the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_tick | input | 1 | One-cycle strobe marking each symbol period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_ack | input | 5 | Per-flag service acknowledge pulse |
| irq | output | 1 | Interrupt request |

## Verification
The cases hardest to reach from the ports are the wrap of the full 32-bit counter and the rule that a committing tick does not count. Counting ticks to the wrap would take billions of cycles. The bench instead stages 0xFFFFFFFD and commits it with one tick. It then checks that the commit tick neither counted nor raised a flag, and steps three ticks to the wrap. The backoff slot is swept over several boundaries. It is also interrupted partway through a slot, to show that the slot count restarts.

// File: rtl/symcnt_pkg.sv
package symcnt_pkg;
  localparam int ADDR_W = 5;
  localparam int FLAG_W = 5;
  localparam logic [ADDR_W-1:0] A_CTRL     = 5'h04;
  localparam logic [ADDR_W-1:0] A_BUSY     = 5'h05;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 5'h06;
  localparam logic [ADDR_W-1:0] A_MASK     = 5'h07;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 5'h10;
  localparam int F_BACKOFF = 4;
  localparam int F_OVF     = 3;
endpackage

// File: rtl/symcnt_core.sv
module symcnt_core #(
  parameter int CNT_W = 32,
  localparam int BYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [BYTES-1:0] byte_we,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] staged_o,
  output logic             busy_o,
  output logic             count_evt,
  output logic [CNT_W-1:0] next_val,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q, stage_q;
  logic             busy_q;

  // a tick counts only when no load waits for it
  assign count_evt = tick & ~busy_q;
  assign next_val  = cnt_q + 1'b1;
  assign ovf_evt   = count_evt & (&cnt_q);

  for (genvar b = 0; b < BYTES; b++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)             stage_q[b*8 +: 8] <= '0;
      else if (byte_we[b]) stage_q[b*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= busy_q ? stage_q : next_val;
      if (byte_we[0])  busy_q <= 1'b1;
      else if (tick)   busy_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign staged_o = stage_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/symcnt_cmp.sv
module symcnt_cmp #(
  parameter int CNT_W = 32,
  localparam int BYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BYTES-1:0] byte_we,
  input  logic [7:0]       wdata,
  input  logic             count_evt,
  input  logic [CNT_W-1:0] next_val,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_evt
);
  logic [CNT_W-1:0] cmp_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)             cmp_q[b*8 +: 8] <= '0;
      else if (byte_we[b]) cmp_q[b*8 +: 8] <= wdata;
    end
  end

  assign match_evt = count_evt && (next_val == cmp_q);
  assign cmp_o     = cmp_q;
endmodule

// File: rtl/symcnt_backoff.sv
module symcnt_backoff #(
  parameter int SLOT_SYMS = 20,
  localparam int SW = $clog2(SLOT_SYMS)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic slot_evt
);
  localparam logic [SW-1:0] LAST = SW'(SLOT_SYMS - 1);
  logic [SW-1:0] slot_q;

  assign slot_evt = en && tick && (slot_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) slot_q <= '0;
    else if (tick)  slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end
endmodule

// File: rtl/symcnt_irq.sv
module symcnt_irq #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_evt,
  input  logic         flags_we,
  input  logic         mask_we,
  input  logic [7:0]   wdata,
  input  logic [W-1:0] ack,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] flags_q, mask_q, flags_n, mask_n, clr;
  logic         irq_q;

  always_comb begin
    clr     = ack | (flags_we ? wdata[W-1:0] : '0);
    flags_n = (flags_q & ~clr) | set_evt;   // a new event beats a clear
    mask_n  = mask_we ? wdata[W-1:0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      mask_q  <= mask_n;
      irq_q   <= |(flags_n & mask_n);
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/symcnt_timer.sv
module symcnt_timer
  import symcnt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_CMP   = 3,
  parameter int SLOT_SYMS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [FLAG_W-1:0] irq_ack,
  output logic              irq
);
  localparam int BYTES = CNT_W / 8;

  logic [BYTES-1:0]   cnt_we;
  logic [CNT_W-1:0]   cnt, staged, next_val;
  logic               busy, count_evt, ovf_evt, slot_evt, low_we;
  logic               ctrl_en;
  logic [FLAG_W-1:0]  flags, mask, set_evt;
  logic [NUM_CMP-1:0] match;
  logic [CNT_W-1:0]   cmp_val [NUM_CMP];
  logic [7:0]         rd_n;

  for (genvar b = 0; b < BYTES; b++) begin : g_cwe
    assign cnt_we[b] = wr_en && (addr == ADDR_W'(b));
  end
  assign low_we = cnt_we[0];

  symcnt_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .tick(sym_tick), .byte_we(cnt_we), .wdata(wdata),
    .cnt_o(cnt), .staged_o(staged), .busy_o(busy), .count_evt(count_evt),
    .next_val(next_val), .ovf_evt(ovf_evt)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [BYTES-1:0] we;
    for (genvar b = 0; b < BYTES; b++) begin : g_we
      assign we[b] = wr_en && (addr == A_CMP_BASE + ADDR_W'(4*k + b));
    end
    symcnt_cmp #(.CNT_W(CNT_W)) cmp_i (
      .clk(clk), .rst(rst), .byte_we(we), .wdata(wdata),
      .count_evt(count_evt), .next_val(next_val),
      .cmp_o(cmp_val[k]), .match_evt(match[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                           ctrl_en <= 1'b0;
    else if (wr_en && addr == A_CTRL)  ctrl_en <= wdata[0];
  end

  symcnt_backoff #(.SLOT_SYMS(SLOT_SYMS)) bo_i (
    .clk(clk), .rst(rst), .en(ctrl_en), .tick(sym_tick), .slot_evt(slot_evt)
  );

  always_comb begin
    set_evt            = '0;
    set_evt[NUM_CMP-1:0] = match;
    set_evt[F_OVF]     = ovf_evt;
    set_evt[F_BACKOFF] = slot_evt;
  end

  symcnt_irq #(.W(FLAG_W)) irq_i (
    .clk(clk), .rst(rst), .set_evt(set_evt),
    .flags_we(wr_en && addr == A_FLAGS), .mask_we(wr_en && addr == A_MASK),
    .wdata(wdata), .ack(irq_ack), .flags_o(flags), .mask_o(mask), .irq_o(irq)
  );

  always_comb begin
    rd_n = '0;
    for (int b = 0; b < BYTES; b++)
      if (addr == ADDR_W'(b)) rd_n = cnt[b*8 +: 8];
    for (int k = 0; k < NUM_CMP; k++)
      for (int b = 0; b < BYTES; b++)
        if (addr == A_CMP_BASE + ADDR_W'(4*k + b)) rd_n = cmp_val[k][b*8 +: 8];
    case (addr)
      A_CTRL:  rd_n = {7'd0, ctrl_en};
      A_BUSY:  rd_n = {7'd0, busy};
      A_FLAGS: rd_n = 8'(flags);
      A_MASK:  rd_n = 8'(mask);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end
endmodule

// File: rtl/symcnt_timer_chk.sv
module symcnt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_tick,
  input logic             low_we,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] staged,
  input logic [4:0]       flags,
  input logic [4:0]       mask,
  input logic             irq
);
  AST_BUSY_ON_LOW_WRITE: assert property (@(posedge clk) disable iff (rst) low_we |=> busy); // R3
  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (rst) busy && sym_tick |=> cnt == $past(staged)); // R4
  AST_COMMIT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst) busy && sym_tick && !low_we |=> !busy); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) !busy && sym_tick |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst) !sym_tick |=> $stable(cnt)); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst) !busy && sym_tick && (&cnt) |=> flags[3]); // R5
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst) irq |-> |(flags & mask)); // R10
endmodule

bind symcnt_timer symcnt_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .sym_tick(sym_tick), .low_we(low_we), .busy(busy),
  .cnt(cnt), .staged(staged), .flags(flags), .mask(mask), .irq(irq)
);

// File: tb/symcnt_timer_tb.sv
module symcnt_timer_tb_top;
  logic       clk = 0, rst = 1, sym_tick = 0, wr_en = 0, irq;
  logic [4:0] addr = '0, irq_ack = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  symcnt_timer dut_i (
    .clk(clk), .rst(rst), .sym_tick(sym_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(5'(i), b); v[i*8 +: 8] = b; end
  endtask

  task automatic wr32(logic [4:0] base, logic [31:0] v);
    for (int i = 3; i >= 0; i--) wr(base + 5'(i), v[i*8 +: 8]);
  endtask

  task automatic tick();
    @(negedge clk); sym_tick = 1;
    @(negedge clk); sym_tick = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    int          sl;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd32(v);          chk("R1 counter", v, 0);
    rd(5'h05, b);     chk("R1 busy", b, 0);
    rd(5'h06, b);     chk("R1 flags", b, 0);
    rd(5'h07, b);     chk("R1 mask", b, 0);
    rd(5'h04, b);     chk("R1 ctrl", b, 0);
    chk("R1 irq", irq, 0);

    // R6, R11: compare values 3, 5, 8; sweep 10 ticks
    wr32(5'h10, 3); wr32(5'h14, 5); wr32(5'h18, 8);
    rd(5'h14, b); chk("R11 cmp2 byte0 readback", b, 5);
    for (int t = 1; t <= 10; t++) begin
      tick();
      rd32(v); chk("R2 count step", v, t);
      rd(5'h06, b);
      chk("R6 compare flags", b, {5'd0, t == 8, t == 5, t == 3});
      wr(5'h06, 8'h07);
    end
    repeat (4) @(negedge clk);
    rd32(v); chk("R2 hold without tick", v, 10);

    // R4 commit does not raise compare; R9 ack clears
    wr32(5'h00, 2);
    tick();
    rd32(v); chk("R4 committed value", v, 2);
    rd(5'h06, b); chk("R4 no flag on commit", b, 0);
    tick();
    rd(5'h06, b); chk("R6 cmp1 at 3", b, 8'h01);
    @(negedge clk); irq_ack = 5'b00001;
    @(negedge clk); irq_ack = 0;
    rd(5'h06, b); chk("R9 ack clears", b, 0);

    // R3/R4/R5 staging and wrap
    wr(5'h03, 8'hFF); wr(5'h02, 8'hFF); wr(5'h01, 8'hFF);
    rd(5'h05, b); chk("R3 no busy on high bytes", b, 0);
    rd32(v); chk("R3 high bytes staged only", v, 3);
    wr(5'h00, 8'hFD);
    rd(5'h05, b); chk("R3 busy set", b, 1);
    rd32(v); chk("R3 counter unchanged while busy", v, 3);
    tick();
    rd(5'h05, b); chk("R4 busy cleared", b, 0);
    rd32(v); chk("R4 load without count", v, 32'hFFFFFFFD);
    tick(); tick();
    rd(5'h06, b); chk("R5 no flag before wrap", b, 0);
    tick();
    rd32(v); chk("R5 wrapped", v, 0);
    rd(5'h06, b); chk("R5 wrap flag", b, 8'h08);
    chk("R10 masked irq low", irq, 0);
    wr(5'h07, 8'h08);
    chk("R10 irq with mask", irq, 1);
    wr(5'h06, 8'hF7);
    rd(5'h06, b); chk("R8 zero bits keep flag", b, 8'h08);
    wr(5'h06, 8'h08);
    rd(5'h06, b); chk("R8 w1c clears", b, 0);
    chk("R10 irq drops", irq, 0);
    wr(5'h06, 8'hE0);
    rd(5'h06, b); chk("R8 reserved read 0", b & 8'hE0, 0);
    wr(5'h07, 8'h00);

    // R7 backoff sweep across boundaries
    wr(5'h04, 8'h01);
    for (int t = 1; t <= 45; t++) begin
      tick();
      rd(5'h06, b);
      chk("R7 slot flag", b[4], (t % 20) == 0);
      if (b[4]) wr(5'h06, 8'h10);
    end
    // disable mid slot restarts the count
    wr(5'h04, 8'h00);
    wr(5'h04, 8'h01);
    sl = 0;
    for (int t = 1; t <= 19; t++) begin
      tick(); rd(5'h06, b); if (b[4]) sl++;
    end
    chk("R7 restart no early flag", sl, 0);
    tick(); rd(5'h06, b);
    chk("R7 flag after 20 from restart", b[4], 1);

    done = 1;
    summary();
  end
endmodule